// File: doc/BRIEF.md
# One-Shot Absolute Address Override

This block sits next to a CPU's bank mapper and gives software a quick way to reach any byte of a 24-bit physical space. Software writes the upper address byte to one I/O port. That single write stores the byte and arms a one-shot flag. The next memory data access (a non-fetch read or write) then uses the stored byte together with the CPU's 16-bit address as its physical address, and the mapper's page registers are not used for it. When that access ends, the flag clears by itself, so all later accesses go back to banked mapping.

The block decodes the CPU's active-low bus strobes (memory request, I/O request, read, write, opcode-fetch and refresh). Opcode fetches and refresh cycles never consume the flag, so the instruction bytes fetched between the port write and the intended load or store do not use up the override. A select output tells the system which address to use: the block's 24-bit address or the mapper's output.

Top module: `abs_addr_override`

## Requirements
- R1: After reset the stored high byte is 0x00 (visible on `phys_addr[23:16]`), and `ovr_sel` is 0 during every access until a port write arms the flag.
- R2: An I/O write (`iorq_n`=0, `wr_n`=0, `rd_n`=1, `m1_n`=1) whose `cpu_addr[7:0]` equals `PORT_ADDR` (default 0x2C) loads `cpu_data` into the high byte. The new value appears on `phys_addr[23:16]` from the next clock edge.
- R3: An I/O write to any other port, and an I/O read of `PORT_ADDR`, leave the high byte unchanged and do not arm the flag.
- R4: After an arming write, the next data access (`mreq_n`=0, `m1_n`=1, `rfsh_n`=1) has `ovr_sel`=1 for all of its cycles, and `phys_addr` = {high byte, `cpu_addr`}.
- R5: Opcode fetches (`m1_n`=0) and refresh cycles (`rfsh_n`=0) show `ovr_sel`=0 and leave the flag armed.
- R6: The flag clears at the first clock edge where `mreq_n` is 1 after the consuming access. The following data access shows `ovr_sel`=0.
- R7: A second port write while the flag is armed replaces the high byte and keeps the flag armed.
- R8: `ovr_sel` is 1 only while a data access is on the bus.
- R9: `phys_addr[15:0]` always equals `cpu_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data bus |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch cycle marker, active low |
| rfsh_n | input | 1 | Refresh cycle marker, active low |
| ovr_sel | output | 1 | 1 selects `phys_addr` over the mapper output |
| phys_addr | output | 24 | {stored high byte, CPU address} |

## Verification
On every cycle, the assertions check these properties: the loading of the high byte and that it is held otherwise, arming and re-arming on a port write, the flag surviving fetch and refresh cycles, the clear when the consuming access ends, and `ovr_sel` appearing only during a data access. Only the bench's scenarios show the end-to-end ordering across a whole instruction. That ordering is: a port write, then a varying number of fetches and refreshes, then exactly one overridden access, then a return to mapping. The scenarios also check that foreign ports and I/O reads are ignored, as seen at the address outputs.

// File: rtl/abs_addr_override_pkg.sv
package abs_addr_override_pkg;
  localparam int unsigned HI_W = 8;
  localparam int unsigned LO_W = 16;
  localparam int unsigned PA_W = HI_W + LO_W;

  typedef struct packed {
    logic mreq;
    logic iorq;
    logic rd;
    logic wr;
    logic m1;
    logic rfsh;
  } bus_ctl_t;
endpackage

// File: rtl/aao_port_decode.sv
module aao_port_decode #(
  parameter int unsigned PORT_W    = 8,
  parameter logic [7:0]  PORT_ADDR = 8'h2C
) (
  input  abs_addr_override_pkg::bus_ctl_t ctl,
  input  logic [PORT_W-1:0]               port_lo,
  output logic                            port_wr,
  output logic                            mem_qual
);
  localparam logic [PORT_W-1:0] MATCH = PORT_W'(PORT_ADDR);

  always_comb begin
    port_wr  = ctl.iorq && ctl.wr && !ctl.rd && !ctl.m1 && (port_lo == MATCH);
    mem_qual = ctl.mreq && !ctl.m1 && !ctl.rfsh;
  end
endmodule

// File: rtl/aao_oneshot_ctrl.sv
module aao_oneshot_ctrl #(
  parameter int unsigned HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            port_wr,
  input  logic            mem_qual,
  input  logic            mreq,
  input  logic            fetch_or_rfsh,
  input  logic [HI_W-1:0] wr_data,
  output logic [HI_W-1:0] hi_q,
  output logic            go_q
);
  logic [HI_W-1:0] hi_d;
  logic            hi_en;
  logic            go_d;
  logic            acc_q, acc_d;

  always_comb begin
    hi_en = port_wr;
    hi_d  = wr_data;
    go_d  = go_q;
    acc_d = acc_q;
    if (port_wr) begin
      go_d  = 1'b1;
      acc_d = 1'b0;
    end else if (acc_q && !mreq) begin
      go_d  = 1'b0;
      acc_d = 1'b0;
    end else if (go_q && mem_qual) begin
      acc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      go_q  <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      if (hi_en) hi_q <= hi_d;
      go_q  <= go_d;
      acc_q <= acc_d;
    end
  end

  a_r2_load_byte: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> hi_q == $past(wr_data));
  a_r3_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !port_wr |=> $stable(hi_q));
  a_r4_arm: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> go_q);
  a_r7_rearm_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && go_q) |=> go_q);
  a_r5_fetch_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !acc_q && fetch_or_rfsh) |=> go_q);
  a_r6_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && !mreq && !port_wr) |=> !go_q);
endmodule

// File: rtl/aao_addr_mux.sv
module aao_addr_mux #(
  parameter int unsigned HI_W = 8,
  parameter int unsigned LO_W = 16
) (
  input  logic [HI_W-1:0]      hi,
  input  logic [LO_W-1:0]      lo,
  input  logic                 go,
  input  logic                 mem_qual,
  output logic [HI_W+LO_W-1:0] phys_addr,
  output logic                 ovr_sel
);
  always_comb begin
    phys_addr = {hi, lo};
    ovr_sel   = go && mem_qual;
  end
endmodule

// File: rtl/abs_addr_override.sv
module abs_addr_override
  import abs_addr_override_pkg::*;
#(
  parameter logic [7:0] PORT_ADDR = 8'h2C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LO_W-1:0]  cpu_addr,
  input  logic [HI_W-1:0]  cpu_data,
  input  logic             mreq_n,
  input  logic             iorq_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             m1_n,
  input  logic             rfsh_n,
  output logic             ovr_sel,
  output logic [PA_W-1:0]  phys_addr
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  bus_ctl_t        ctl;
  logic            port_wr, mem_qual;
  logic [HI_W-1:0] hi_q;
  logic            go_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    ctl.mreq = !mreq_n;
    ctl.iorq = !iorq_n;
    ctl.rd   = !rd_n;
    ctl.wr   = !wr_n;
    ctl.m1   = !m1_n;
    ctl.rfsh = !rfsh_n;
  end

  aao_port_decode #(.PORT_W(8), .PORT_ADDR(PORT_ADDR)) u_dec (
    .ctl(ctl), .port_lo(cpu_addr[7:0]), .port_wr(port_wr), .mem_qual(mem_qual)
  );

  aao_oneshot_ctrl #(.HI_W(HI_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .port_wr(port_wr), .mem_qual(mem_qual),
    .mreq(ctl.mreq), .fetch_or_rfsh(ctl.m1 || ctl.rfsh), .wr_data(cpu_data),
    .hi_q(hi_q), .go_q(go_q)
  );

  aao_addr_mux #(.HI_W(HI_W), .LO_W(LO_W)) u_mux (
    .hi(hi_q), .lo(cpu_addr), .go(go_q), .mem_qual(mem_qual),
    .phys_addr(phys_addr), .ovr_sel(ovr_sel)
  );

  a_r8_sel_only_data: assert property (@(posedge clk) disable iff (!rst_int_n)
    ovr_sel |-> (!mreq_n && m1_n && rfsh_n));
  a_r9_low_passthru: assert property (@(posedge clk) disable iff (!rst_int_n)
    phys_addr[LO_W-1:0] == cpu_addr);
endmodule

// File: tb/abs_addr_override_test.sv
module abs_addr_override_test;
  localparam logic [7:0] PORT = 8'h2C;
  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n;
  logic ovr_sel;
  logic [23:0] phys_addr;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [7:0] exp_hi;
  logic       exp_go;

  always #2 clk = ~clk;

  abs_addr_override #(.PORT_ADDR(PORT)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .m1_n(m1_n), .rfsh_n(rfsh_n), .ovr_sel(ovr_sel), .phys_addr(phys_addr)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles, expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input logic [23:0] act, input logic [23:0] expv, input string tag);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic idle();
    cpu_addr = 16'h0; cpu_data = 8'h0;
    mreq_n = 1; iorq_n = 1; rd_n = 1; wr_n = 1; m1_n = 1; rfsh_n = 1;
  endtask

  // kind 0: io write, 1: io read
  task automatic io_cycle(input logic [7:0] port, input logic [7:0] d, input int kind);
    @(negedge clk);
    cpu_addr = {8'h00, port}; cpu_data = d; iorq_n = 0;
    if (kind == 0) wr_n = 0; else rd_n = 0;
    @(negedge clk);
    idle();
    if (kind == 0 && port == PORT) begin exp_hi = d; exp_go = 1; end
    #1 chk({16'h0, phys_addr[23:16]}, {16'h0, exp_hi}, "R2/R3 high byte after io");
  endtask

  // kind 0 read, 1 write, 2 opcode fetch, 3 refresh
  task automatic mem_cycle(input logic [15:0] a, input int kind);
    logic want;
    want = exp_go && (kind < 2);
    @(negedge clk);
    cpu_addr = a; mreq_n = 0;
    case (kind)
      0: rd_n = 0;
      1: begin wr_n = 0; cpu_data = a[7:0]; end
      2: begin m1_n = 0; rd_n = 0; end
      default: rfsh_n = 0;
    endcase
    for (int k = 0; k < 2; k++) begin
      #1;
      if (kind >= 2) chk({23'h0, ovr_sel}, 24'h0, "R5/R8 fetch or refresh not overridden");
      else chk({23'h0, ovr_sel}, {23'h0, want}, "R4/R6 ovr_sel during data access");
      chk(phys_addr, {exp_hi, a}, "R4/R9 physical address");
      @(negedge clk);
    end
    idle();
    if (want) exp_go = 0;
  endtask

  initial begin
    idle();
    exp_hi = 8'h00; exp_go = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    chk({16'h0, phys_addr[23:16]}, 24'h0, "R1 reset high byte");
    chk({23'h0, ovr_sel}, 24'h0, "R1 reset ovr_sel idle");
    mem_cycle(16'h1234, 0);   // R1: not armed, no override

    for (int i = 0; i < 16; i++) begin
      logic [7:0] hb;
      hb = 8'((i * 17) ^ 8'h5A);
      io_cycle(PORT, hb, 0);                       // R2 arm
      for (int f = 0; f < i % 3; f++) mem_cycle(16'(i * 256 + f), 2); // R5 fetches
      for (int r = 0; r < i % 2; r++) mem_cycle(16'(r + 7), 3);       // R5 refresh
      if (i % 4 == 0) begin
        io_cycle(PORT, ~hb, 0);                    // R7 rewrite while armed
        mem_cycle(16'h00FF, 2);
      end
      mem_cycle(16'(i * 4097), i % 2);             // R4 consuming access
      mem_cycle(16'(i * 4097 + 1), (i + 1) % 2);   // R6 back to mapping
      io_cycle(PORT ^ 8'(1 << (i % 8)), 8'(i), 0); // R3 foreign port
      io_cycle(PORT, 8'(i + 99), 1);               // R3 io read of port
      mem_cycle(16'(i), 0);                        // R3 not armed
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule